// File: doc/BRIEF.md
# L2 Request Service Controller

This block sits between the interconnect and the memory-side cache of one memory partition. Requests arrive on a valid/ready port and wait in one of two internal input queues. A single holding register takes one request at a time and looks it up through a hit/miss port to the tag array. A read hit is returned on the reply port. A write hit is absorbed. A miss is registered with the miss-status tracker through a new-miss port. When the tracker reports that the miss did not merge with a miss already in flight, the request is placed in an internal to-memory queue.

A separate arbiter feeds the DRAM scheduler. It offers pending cache writebacks before queued misses, and it moves an entry only while the scheduler can accept one. Two mode inputs change the behaviour. The first gives reads priority by steering writes into their own input queue. The second makes every lookup count as a hit. Six counters record completed accesses, read hits, write hits, registered misses, and the reads and writes sent to DRAM.

Top module: `l2_req_ctrl`

## Requirements
- R1: When `readPrio` is 1, an accepted write (`reqWrite`=1) is stored in the write input queue. Every other accepted request is stored in the main input queue. Each queue keeps arrival order.
- R2: `reqReady` is 1 exactly when neither input queue holds `IN_DEPTH` entries. A request is accepted on a cycle with `reqValid` and `reqReady` both 1.
- R3: The holding register loads a new request only on a cycle in which it is empty. It takes the head of the main queue when that queue has an entry, and otherwise the head of the write queue. While it holds a request, `lkValid` is 1 and `lkAddr` carries that request's address.
- R4: A held read that hits drives `rspValid`=1 with its address on `rspAddr`. It completes only in a cycle with `rspReady`=1, and only then are `rdHitCnt` and `accCnt` incremented. While `rspReady` is 0 the request stays held and nothing is counted.
- R5: A held write that hits completes in the same cycle. It increments `wrHitCnt` and `accCnt` and produces no reply and no memory traffic.
- R6: For a held miss while the to-memory queue holds `MISS_DEPTH` entries, `mshrValid` stays 0, the request stays held, and no counter changes. Otherwise `mshrValid` is 1 with `mshrAddr` set to the request address, the miss completes, and `missCnt` and `accCnt` are incremented.
- R7: When `mshrMerged` is 1, a registered miss sends nothing to memory. When it is 0, the miss enters the to-memory queue. A read keeps its size, and a write's size is reduced by `HDR_BYTES` because writes are not allocated in the cache.
- R8: `dramValid` is 1 while a writeback is offered (`wbValid`) or the to-memory queue holds an entry. A writeback is always presented first, with `dramWrite`=1 and `dramSize`=`LINE_BYTES`. An entry transfers when `dramReady` is 1, and `wbReady` equals `dramReady`. Each transfer increments `memWrCnt` for a write and `memRdCnt` for a read.
- R9: When `idealMode` is 1, every lookup is treated as a hit, whatever `lkHit` says.
- R10: After reset, all counters are 0, `rspValid`, `mshrValid`, `lkValid` and `dramValid` (with no writeback offered) are 0, and `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readPrio | input | 1 | Steer writes into the separate write queue |
| idealMode | input | 1 | Treat every lookup as a hit |
| reqValid | input | 1 | Incoming request valid |
| reqReady | output | 1 | Both input queues have room |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | Request is a write |
| reqSize | input | SIZE_W | Request size in bytes |
| lkValid | output | 1 | Lookup of the held request |
| lkAddr | output | ADDR_W | Lookup address |
| lkHit | input | 1 | Tag array reports a hit |
| mshrValid | output | 1 | Register a new miss |
| mshrAddr | output | ADDR_W | Address of the new miss |
| mshrMerged | input | 1 | Miss merged with one in flight |
| rspValid | output | 1 | Read reply valid |
| rspReady | input | 1 | Reply queue has room |
| rspAddr | output | ADDR_W | Reply address |
| wbValid | input | 1 | Cache writeback pending |
| wbReady | output | 1 | Writeback accepted |
| wbAddr | input | ADDR_W | Writeback address |
| dramValid | output | 1 | Entry offered to the DRAM scheduler |
| dramReady | input | 1 | DRAM scheduler not full |
| dramAddr | output | ADDR_W | Address to DRAM |
| dramWrite | output | 1 | Entry is a write |
| dramSize | output | SIZE_W | Transfer size in bytes |
| accCnt | output | CNT_W | Completed accesses |
| rdHitCnt | output | CNT_W | Read hits |
| wrHitCnt | output | CNT_W | Write hits |
| missCnt | output | CNT_W | Registered misses |
| memRdCnt | output | CNT_W | Reads sent to DRAM |
| memWrCnt | output | CNT_W | Writes sent to DRAM |

## Verification
The bench stalls the reply port for long stretches. A design that counts a stalled read hit more than once, or drops it, then shows a reply count or address that differs from the model. The bench also starves the DRAM side so that the to-memory queue fills. If the design registers misses with the tracker while that queue is full, stray `mshrValid` pulses and extra miss counts show up. Concurrent writebacks catch an arbiter that lets queued misses overtake them. Read-priority and ideal phases expose a reversed queue preference or a lookup result used in the wrong mode, and merged and unmerged write misses show whether the header size is subtracted where it should be.

// File: rtl/l2rsc_pkg.sv
package l2rsc_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic pushMain;
    logic pushWr;
    logic loadMain;
    logic loadWr;
    logic finish;
    logic pushMiss;
    logic popMiss;
    logic selWb;
    logic cntAcc;
    logic cntRdHit;
    logic cntWrHit;
    logic cntMiss;
    logic cntMemRd;
    logic cntMemWr;
  } ctlStrobes_t;
endpackage

// File: rtl/l2rsc_fifo.sv
module l2rsc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = store[rdPtr];

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + PW'(1);
      if (pop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + PW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2: nothing is written into a full queue
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN) push |-> !full);
  // R3: nothing is read from an empty queue
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty);
endmodule

// File: rtl/l2rsc_control.sv
module l2rsc_control
  import l2rsc_pkg::*;
(
  input  logic        readPrio,
  input  logic        idealMode,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        lkHit,
  input  logic        mshrMerged,
  input  logic        rspReady,
  input  logic        wbValid,
  input  logic        dramReady,
  input  logic        mainFull,
  input  logic        mainEmpty,
  input  logic        wrFull,
  input  logic        wrEmpty,
  input  logic        missFull,
  input  logic        missEmpty,
  input  logic        missHeadWrite,
  input  logic        heldValid,
  input  logic        heldWrite,
  output logic        reqReady,
  output logic        lkValid,
  output logic        rspValid,
  output logic        mshrValid,
  output logic        wbReady,
  output logic        dramValid,
  output ctlStrobes_t st
);
  logic hitEff, readHit, writeHit, missIn, rdDone, accept, toWrQ, xfer;

  always_comb begin
    hitEff   = idealMode | lkHit;
    readHit  = heldValid & hitEff & ~heldWrite;
    writeHit = heldValid & hitEff & heldWrite;
    missIn   = heldValid & ~hitEff;
    rdDone   = readHit & rspReady;

    reqReady  = ~mainFull & ~wrFull;
    accept    = reqValid & reqReady;
    toWrQ     = readPrio & reqWrite;
    lkValid   = heldValid;
    rspValid  = readHit;
    mshrValid = missIn & ~missFull;

    dramValid = wbValid | ~missEmpty;
    wbReady   = dramReady;
    xfer      = dramValid & dramReady;

    st          = '0;
    st.pushMain = accept & ~toWrQ;
    st.pushWr   = accept & toWrQ;
    st.loadMain = ~heldValid & ~mainEmpty;
    st.loadWr   = ~heldValid & mainEmpty & ~wrEmpty;
    st.finish   = rdDone | writeHit | mshrValid;
    st.pushMiss = mshrValid & ~mshrMerged;
    st.selWb    = wbValid;
    st.popMiss  = dramReady & ~wbValid & ~missEmpty;
    st.cntAcc   = rdDone | writeHit | mshrValid;
    st.cntRdHit = rdDone;
    st.cntWrHit = writeHit;
    st.cntMiss  = mshrValid;
    st.cntMemWr = xfer & (wbValid | missHeadWrite);
    st.cntMemRd = xfer & ~wbValid & ~missHeadWrite;
  end
endmodule

// File: rtl/l2rsc_datapath.sv
module l2rsc_datapath
  import l2rsc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 8,
  parameter int HDR_BYTES  = 8,
  parameter int LINE_BYTES = 64,
  parameter int IN_DEPTH   = 4,
  parameter int MISS_DEPTH = 2,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       st,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [ADDR_W-1:0] wbAddr,
  input  logic              wbValid,
  input  logic              dramValid,
  output logic              mainFull,
  output logic              mainEmpty,
  output logic              wrFull,
  output logic              wrEmpty,
  output logic              missFull,
  output logic              missEmpty,
  output logic              missHeadWrite,
  output logic              heldValid,
  output logic              heldWrite,
  output logic [ADDR_W-1:0] lkAddr,
  output logic [ADDR_W-1:0] mshrAddr,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              dramWrite,
  output logic [SIZE_W-1:0] dramSize,
  output logic [CNT_W-1:0]  accCnt,
  output logic [CNT_W-1:0]  rdHitCnt,
  output logic [CNT_W-1:0]  wrHitCnt,
  output logic [CNT_W-1:0]  missCnt,
  output logic [CNT_W-1:0]  memRdCnt,
  output logic [CNT_W-1:0]  memWrCnt
);
  localparam int EW   = 1 + SIZE_W + ADDR_W;
  localparam int NCNT = 6;

  logic [EW-1:0]     reqEntry, mainHead, wrHead, missIn, missHead;
  logic [ADDR_W-1:0] heldAddr;
  logic [SIZE_W-1:0] heldSize, missSize;

  assign reqEntry = {reqWrite, reqSize, reqAddr};

  l2rsc_fifo #(.W(EW), .DEPTH(IN_DEPTH)) uMainQ (
    .clk(clk), .rstN(rstN), .push(st.pushMain), .din(reqEntry),
    .pop(st.loadMain), .dout(mainHead), .full(mainFull), .empty(mainEmpty));

  l2rsc_fifo #(.W(EW), .DEPTH(IN_DEPTH)) uWrQ (
    .clk(clk), .rstN(rstN), .push(st.pushWr), .din(reqEntry),
    .pop(st.loadWr), .dout(wrHead), .full(wrFull), .empty(wrEmpty));

  // Write misses shed the header: no allocation, data goes straight out
  assign missSize = heldWrite ? heldSize - SIZE_W'(HDR_BYTES) : heldSize;
  assign missIn   = {heldWrite, missSize, heldAddr};

  l2rsc_fifo #(.W(EW), .DEPTH(MISS_DEPTH)) uMissQ (
    .clk(clk), .rstN(rstN), .push(st.pushMiss), .din(missIn),
    .pop(st.popMiss), .dout(missHead), .full(missFull), .empty(missEmpty));

  assign missHeadWrite = missHead[EW-1];

  // Holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldValid <= 1'b0;
      heldWrite <= 1'b0;
      heldAddr  <= '0;
      heldSize  <= '0;
    end else if (st.loadMain || st.loadWr) begin
      heldValid <= 1'b1;
      {heldWrite, heldSize, heldAddr} <= st.loadMain ? mainHead : wrHead;
    end else if (st.finish) begin
      heldValid <= 1'b0;
    end
  end

  assign lkAddr   = heldAddr;
  assign mshrAddr = heldAddr;
  assign rspAddr  = heldAddr;

  // DRAM-side mux: writeback wins
  always_comb begin
    if (st.selWb) begin
      dramAddr  = wbAddr;
      dramWrite = 1'b1;
      dramSize  = SIZE_W'(LINE_BYTES);
    end else begin
      dramAddr  = missHead[ADDR_W-1:0];
      dramWrite = missHead[EW-1];
      dramSize  = missHead[ADDR_W +: SIZE_W];
    end
  end

  // Event counters
  logic [NCNT-1:0]  incV;
  logic [CNT_W-1:0] cnt [NCNT];

  assign incV = {st.cntMemWr, st.cntMemRd, st.cntMiss, st.cntWrHit, st.cntRdHit, st.cntAcc};

  for (genvar gi = 0; gi < NCNT; gi++) begin : gCnt
    always_ff @(posedge clk) begin
      if (!rstN)         cnt[gi] <= '0;
      else if (incV[gi]) cnt[gi] <= cnt[gi] + CNT_W'(1);
    end
  end

  assign accCnt   = cnt[0];
  assign rdHitCnt = cnt[1];
  assign wrHitCnt = cnt[2];
  assign missCnt  = cnt[3];
  assign memRdCnt = cnt[4];
  assign memWrCnt = cnt[5];

  // R3: a held request keeps its identity until it completes
  a_r3_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    heldValid && !st.finish |=> heldValid && $stable(heldAddr) && $stable(heldWrite));
  // R8: an offered writeback is what the scheduler sees
  a_r8_wb_first: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && dramValid |-> dramAddr == wbAddr && dramWrite);
  // R6: every completed access is exactly one of read hit, write hit or miss
  a_r6_access_sum: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (accCnt - $past(accCnt)) ==
             (rdHitCnt - $past(rdHitCnt)) + (wrHitCnt - $past(wrHitCnt)) + (missCnt - $past(missCnt)));
endmodule

// File: rtl/l2_req_ctrl.sv
module l2_req_ctrl
  import l2rsc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 8,
  parameter int HDR_BYTES  = 8,
  parameter int LINE_BYTES = 64,
  parameter int IN_DEPTH   = 4,
  parameter int MISS_DEPTH = 2,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readPrio,
  input  logic              idealMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              lkValid,
  output logic [ADDR_W-1:0] lkAddr,
  input  logic              lkHit,
  output logic              mshrValid,
  output logic [ADDR_W-1:0] mshrAddr,
  input  logic              mshrMerged,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspAddr,
  input  logic              wbValid,
  output logic              wbReady,
  input  logic [ADDR_W-1:0] wbAddr,
  output logic              dramValid,
  input  logic              dramReady,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              dramWrite,
  output logic [SIZE_W-1:0] dramSize,
  output logic [CNT_W-1:0]  accCnt,
  output logic [CNT_W-1:0]  rdHitCnt,
  output logic [CNT_W-1:0]  wrHitCnt,
  output logic [CNT_W-1:0]  missCnt,
  output logic [CNT_W-1:0]  memRdCnt,
  output logic [CNT_W-1:0]  memWrCnt
);
  ctlStrobes_t st;
  logic mainFull, mainEmpty, wrFull, wrEmpty, missFull, missEmpty;
  logic missHeadWrite, heldValid, heldWrite;

  l2rsc_control uCtl (
    .readPrio(readPrio), .idealMode(idealMode), .reqValid(reqValid), .reqWrite(reqWrite),
    .lkHit(lkHit), .mshrMerged(mshrMerged), .rspReady(rspReady), .wbValid(wbValid),
    .dramReady(dramReady), .mainFull(mainFull), .mainEmpty(mainEmpty), .wrFull(wrFull),
    .wrEmpty(wrEmpty), .missFull(missFull), .missEmpty(missEmpty),
    .missHeadWrite(missHeadWrite), .heldValid(heldValid), .heldWrite(heldWrite),
    .reqReady(reqReady), .lkValid(lkValid), .rspValid(rspValid), .mshrValid(mshrValid),
    .wbReady(wbReady), .dramValid(dramValid), .st(st));

  l2rsc_datapath #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .HDR_BYTES(HDR_BYTES), .LINE_BYTES(LINE_BYTES),
    .IN_DEPTH(IN_DEPTH), .MISS_DEPTH(MISS_DEPTH), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSize(reqSize), .wbAddr(wbAddr), .wbValid(wbValid), .dramValid(dramValid),
    .mainFull(mainFull), .mainEmpty(mainEmpty), .wrFull(wrFull), .wrEmpty(wrEmpty),
    .missFull(missFull), .missEmpty(missEmpty), .missHeadWrite(missHeadWrite),
    .heldValid(heldValid), .heldWrite(heldWrite), .lkAddr(lkAddr), .mshrAddr(mshrAddr),
    .rspAddr(rspAddr), .dramAddr(dramAddr), .dramWrite(dramWrite), .dramSize(dramSize),
    .accCnt(accCnt), .rdHitCnt(rdHitCnt), .wrHitCnt(wrHitCnt), .missCnt(missCnt),
    .memRdCnt(memRdCnt), .memWrCnt(memWrCnt));

  // R4: a stalled reply stays offered with the same address
  a_r4_reply_held: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady && !idealMode && $stable(idealMode) |=> rspValid && $stable(rspAddr));
endmodule

// File: tb/l2_req_ctrl_test.sv
`timescale 1ns/1ps
module l2_req_ctrl_test;
  localparam int AW = 16, SW = 8, HDR = 8, LINE = 64, IND = 4, MD = 2, CW = 16;
  localparam int NCYC = 12000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readPrio = 0, idealMode = 0, reqValid = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0, wbAddr = '0;
  logic [SW-1:0] reqSize = 8'd8;
  logic rspReady = 0, wbValid = 0, dramReady = 0;
  logic reqReady, lkValid, mshrValid, rspValid, wbReady, dramValid, dramWrite;
  logic [AW-1:0] lkAddr, mshrAddr, rspAddr, dramAddr;
  logic [SW-1:0] dramSize;
  logic [CW-1:0] accCnt, rdHitCnt, wrHitCnt, missCnt, memRdCnt, memWrCnt;
  logic lkHit, mshrMerged;

  // Tag array and tracker stand-ins: hit when address bit 3 is set, merge when bit 4 is set
  assign lkHit      = lkAddr[3];
  assign mshrMerged = mshrAddr[4];

  always #2 clk = ~clk;

  l2_req_ctrl uut (
    .clk(clk), .rstN(rstN), .readPrio(readPrio), .idealMode(idealMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSize(reqSize), .lkValid(lkValid), .lkAddr(lkAddr), .lkHit(lkHit),
    .mshrValid(mshrValid), .mshrAddr(mshrAddr), .mshrMerged(mshrMerged),
    .rspValid(rspValid), .rspReady(rspReady), .rspAddr(rspAddr),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr),
    .dramValid(dramValid), .dramReady(dramReady), .dramAddr(dramAddr),
    .dramWrite(dramWrite), .dramSize(dramSize), .accCnt(accCnt), .rdHitCnt(rdHitCnt),
    .wrHitCnt(wrHitCnt), .missCnt(missCnt), .memRdCnt(memRdCnt), .memWrCnt(memWrCnt));

  int vectors = 0, miscompares = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference state: entries are {write, size, addr}
  bit [24:0] mq[$], wq[$], missq[$];
  bit        hv;
  bit [24:0] hEnt;
  int cAcc, cRd, cWh, cMiss, cMemRd, cMemWr;

  initial begin
    #(4 * (NCYC + 500));
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    hv = 0; cAcc = 0; cRd = 0; cWh = 0; cMiss = 0; cMemRd = 0; cMemWr = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R10 reset state
    check("R10 accCnt", int'(accCnt), 0);
    check("R10 rdHitCnt", int'(rdHitCnt), 0);
    check("R10 memWrCnt", int'(memWrCnt), 0);
    check("R10 rspValid", int'(rspValid), 0);
    check("R10 dramValid", int'(dramValid), 0);
    check("R10 lkValid", int'(lkValid), 0);
    check("R10 reqReady", int'(reqReady), 1);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int ph, rsPct, drPct, wbPct, rqPct;
      bit hit, hW, mFullNow, readyNow, eDramV;
      bit [15:0] hA;
      bit [7:0] hS;
      bit [24:0] e;
      string hitTag;
      ph = cyc / 2000;
      @(negedge clk);
      readPrio  = (ph == 1 || ph == 5);
      idealMode = (ph == 4);
      rsPct = (ph == 2) ? 10 : ((ph == 5) ? (((cyc / 40) % 2 == 1) ? 90 : 0) : 80);
      drPct = (ph == 3) ? 5 : 80;
      wbPct = (ph == 3) ? 50 : 15;
      rqPct = (ph == 5) ? 90 : 60;
      reqValid  = ($urandom % 100) < rqPct;
      reqAddr   = 16'($urandom);
      reqWrite  = $urandom % 2;
      reqSize   = 8'(HDR + $urandom % 64);
      rspReady  = ($urandom % 100) < rsPct;
      dramReady = ($urandom % 100) < drPct;
      wbValid   = ($urandom % 100) < wbPct;
      wbAddr    = 16'($urandom);
      #1;
      hitTag = idealMode ? "R9" : "R4";
      {hW, hS, hA} = hEnt;
      hit = idealMode | hA[3];
      readyNow = (mq.size() < IND) && (wq.size() < IND);
      mFullNow = (missq.size() >= MD);
      eDramV = wbValid || (missq.size() > 0);

      check("R2 reqReady", int'(reqReady), int'(readyNow));
      check("R3 lkValid", int'(lkValid), int'(hv));
      if (hv) check("R1 lkAddr", int'(lkAddr), int'(hA));
      check({hitTag, " rspValid"}, int'(rspValid), int'(hv && hit && !hW));
      if (hv && hit && !hW) check("R4 rspAddr", int'(rspAddr), int'(hA));
      check("R6 mshrValid", int'(mshrValid), int'(hv && !hit && !mFullNow));
      if (mshrValid) check("R6 mshrAddr", int'(mshrAddr), int'(hA));
      check("R8 dramValid", int'(dramValid), int'(eDramV));
      check("R8 wbReady", int'(wbReady), int'(dramReady));
      if (eDramV) begin
        if (wbValid) begin
          check("R8 dramAddr", int'(dramAddr), int'(wbAddr));
          check("R8 dramWrite", int'(dramWrite), 1);
          check("R8 dramSize", int'(dramSize), LINE);
        end else begin
          check("R8 dramAddr", int'(dramAddr), int'(missq[0][15:0]));
          check("R7 dramWrite", int'(dramWrite), int'(missq[0][24]));
          check("R7 dramSize", int'(dramSize), int'(missq[0][23:16]));
        end
      end
      check("R6 accCnt", int'(accCnt), cAcc % 65536);
      check({hitTag, " rdHitCnt"}, int'(rdHitCnt), cRd % 65536);
      check("R5 wrHitCnt", int'(wrHitCnt), cWh % 65536);
      check("R6 missCnt", int'(missCnt), cMiss % 65536);
      check("R8 memRdCnt", int'(memRdCnt), cMemRd % 65536);
      check("R8 memWrCnt", int'(memWrCnt), cMemWr % 65536);

      // Advance the model to the state after the coming edge
      if (wbValid && dramReady) cMemWr++;
      else if (dramReady && missq.size() > 0) begin
        e = missq.pop_front();
        if (e[24]) cMemWr++; else cMemRd++;
      end
      if (hv) begin
        if (hit && !hW) begin
          if (rspReady) begin cAcc++; cRd++; hv = 0; end
        end else if (hit) begin
          cAcc++; cWh++; hv = 0;
        end else if (!mFullNow) begin
          cAcc++; cMiss++; hv = 0;
          if (!hA[4]) missq.push_back({hW, hW ? 8'(hS - 8'(HDR)) : hS, hA});
        end
      end else if (mq.size() > 0) begin
        hEnt = mq.pop_front(); hv = 1;
      end else if (wq.size() > 0) begin
        hEnt = wq.pop_front(); hv = 1;
      end
      if (reqValid && readyNow) begin
        if (readPrio && reqWrite) wq.push_back({reqWrite, reqSize, reqAddr});
        else mq.push_back({reqWrite, reqSize, reqAddr});
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule